// File: doc/BRIEF.md
# CPU Event Arbiter with NMI Tracking

This block sits next to a small processor core and chooses which pending external event the core takes next. Events are taken only when the core signals an instruction boundary. During long string moves the core also raises that boundary strobe between individual memory transfers. The block looks at three sources in a fixed order: a system-management request, a non-maskable interrupt, and a maskable interrupt level. For the event it picks, it gives a one-cycle take pulse and the handler vector that goes with it.

There is no NMI pin. Software raises an NMI by writing a configuration bit, and the block treats a 0-to-1 change of that bit as one request. After an NMI is taken, later NMIs are blocked until the handler returns. While they are blocked, one request is held and any others are dropped. A maskable interrupt taken inside the NMI handler opens a nested level. The return from that nested handler does not end the NMI window.

A maskable interrupt gets its vector from an external controller through a request/valid handshake. A wake signal tells a halted core to resume. Only the system-management request or an enabled maskable interrupt can raise wake.

Top module: `evt_arbiter`

## Requirements
- R1: When `insn_bnd` is high and no handshake is in flight, the block takes the highest-priority ready source, in the order SMI, then NMI, then INTR. Each take output is a pulse one cycle long, and at most one take output is high in any cycle.
- R2: An NMI request is recorded on a 0-to-1 change of `nmi_ctl`, seen one clock after the change. Holding `nmi_ctl` high does not record another request.
- R3: A taken NMI raises `take_nmi` in the cycle after the boundary, with `vector` = 2 (the `NMI_VEC` default). `ack_req` does not rise for it.
- R4: INTR is considered only while `ie_flag` is 1. With `ie_flag` at 0, a boundary with `intr_lvl` high starts no handshake and takes nothing.
- R5: A taken INTR raises `ack_req` from the cycle after the boundary. `ack_req` stays high until `ack_valid` is sampled high. In the next cycle `ack_req` is low, `take_intr` is high, and `vector` equals the `ack_vec` value that was sampled.
- R6: While `ack_req` is high, boundary strobes are ignored. No SMI or NMI is taken until the handshake ends.
- R7: After an NMI is taken, NMIs are blocked until `iret_done` pulses. During the blocked window exactly one new request is held, and it is taken at the first boundary after the closing `iret_done`. Any further requests in that window are lost.
- R8: An INTR taken while NMIs are blocked adds a nested level. The next `iret_done` closes only that level, and NMIs stay blocked until one more `iret_done` arrives.
- R9: No take output rises in a cycle that does not follow a high `insn_bnd`, except `take_intr` at the end of a handshake.
- R10: `wake` is registered. It is high in the cycle after `core_halted` is high together with `smi_req`, or with `intr_lvl` and `ie_flag`. A pending NMI never raises `wake`.
- R11: Reset clears the take outputs, `vector`, `ack_req`, `wake`, the blocked state, the nesting count and the held NMI request.
- R12: A taken SMI raises `take_smi` in the cycle after the boundary, with `vector` = 0 (the `SMI_VEC` default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_req | input | 1 | System-management request level |
| intr_lvl | input | 1 | Maskable interrupt request level |
| nmi_ctl | input | 1 | Software NMI control bit; a rising edge requests an NMI |
| ie_flag | input | 1 | Interrupt-enable flag from the core |
| insn_bnd | input | 1 | Instruction (or string-move) boundary strobe |
| iret_done | input | 1 | Pulse: the core executed an interrupt return |
| core_halted | input | 1 | The core is halted |
| ack_valid | input | 1 | The external controller presents the vector |
| ack_vec | input | VEC_W | Vector from the external controller |
| ack_req | output | 1 | Interrupt-acknowledge request to the controller |
| take_smi | output | 1 | One-cycle pulse: take the SMI |
| take_nmi | output | 1 | One-cycle pulse: take the NMI |
| take_intr | output | 1 | One-cycle pulse: take the INTR |
| vector | output | VEC_W | Vector of the most recently taken event |
| wake | output | 1 | Resume request for a halted core |

## Verification
The bench drives the three sources one at a time, then all at once. Single-source runs confirm each vector and whether a handshake is used. The combined run shows that the priority order is applied and not just the order of arrival. The NMI control bit is toggled several times inside a blocked window, which tells "one edge held" apart from "every edge queued" and from "none held". An NMI handler with a nested INTR separates a return counted per level from a return that clears everything. Further runs check boundaries that arrive during a handshake, wake combinations with an NMI pending, and a reset in the middle of a handshake. Together these show which inputs are ignored and which state is cleared.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;

    typedef enum logic {
        ACK_IDLE = 1'b0,
        ACK_WAIT = 1'b1
    } ack_state_e;

endpackage

// File: rtl/evt_nmi_track.sv
`timescale 1ns/1ps
module evt_nmi_track #(
    parameter int NEST_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_ctl,
    input  logic take_nmi,
    input  logic take_intr,
    input  logic iret_done,
    output logic nmi_ready,
    output logic nmi_blocked
);
    localparam logic [NEST_W-1:0] LVL_ONE = {{(NEST_W-1){1'b0}}, 1'b1};
    localparam logic [NEST_W-1:0] LVL_MAX = {NEST_W{1'b1}};

    typedef struct packed {
        logic              prev;
        logic              held;
        logic              blocked;
        logic [NEST_W-1:0] nest;
    } trk_t;

    trk_t s_d, s_q;
    logic rise;

    always_comb begin
        s_d    = s_q;
        rise   = nmi_ctl & ~s_q.prev;
        s_d.prev = nmi_ctl;
        // one held request; further edges merge into it
        s_d.held = (s_q.held & ~take_nmi) | rise;
        // a return closes the innermost open level
        if (iret_done && s_q.blocked) begin
            if (s_q.nest != '0) begin
                s_d.nest = s_q.nest - LVL_ONE;
            end else begin
                s_d.blocked = 1'b0;
            end
        end
        // an INTR taken inside the NMI window opens a nested level
        if (take_intr && s_d.blocked && s_d.nest != LVL_MAX) begin
            s_d.nest = s_d.nest + LVL_ONE;
        end
        if (take_nmi) begin
            s_d.blocked = 1'b1;
            s_d.nest    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign nmi_ready   = s_q.held & ~s_q.blocked;
    assign nmi_blocked = s_q.blocked;
endmodule

// File: rtl/evt_ack_fsm.sv
`timescale 1ns/1ps
module evt_ack_fsm
    import evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack_valid,
    output logic busy,
    output logic done
);
    ack_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        unique case (st_q)
            ACK_IDLE: if (start) st_d = ACK_WAIT;
            ACK_WAIT: if (ack_valid) begin
                st_d = ACK_IDLE;
                done = 1'b1;
            end
            default: st_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ACK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q == ACK_WAIT);
endmodule

// File: rtl/evt_select.sv
`timescale 1ns/1ps
module evt_select #(
    parameter int NSRC = 3
) (
    input  logic            boundary,
    input  logic            busy,
    input  logic [NSRC-1:0] ready,
    output logic [NSRC-1:0] grant
);
    // ready[0] has the highest priority
    logic [NSRC-1:0] above;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_pri
            if (i == 0) begin : g_top
                assign above[i] = 1'b0;
            end else begin : g_low
                assign above[i] = above[i-1] | ready[i-1];
            end
            assign grant[i] = boundary & ~busy & ready[i] & ~above[i];
        end
    endgenerate
endmodule

// File: rtl/evt_arbiter.sv
`timescale 1ns/1ps
module evt_arbiter #(
    parameter int VEC_W   = 8,
    parameter int NEST_W  = 4,
    parameter int NMI_VEC = 2,
    parameter int SMI_VEC = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smi_req,
    input  logic             intr_lvl,
    input  logic             nmi_ctl,
    input  logic             ie_flag,
    input  logic             insn_bnd,
    input  logic             iret_done,
    input  logic             core_halted,
    input  logic             ack_valid,
    input  logic [VEC_W-1:0] ack_vec,
    output logic             ack_req,
    output logic             take_smi,
    output logic             take_nmi,
    output logic             take_intr,
    output logic [VEC_W-1:0] vector,
    output logic             wake
);
    localparam int NSRC = 3;
    localparam int I_SMI = 0;
    localparam int I_NMI = 1;
    localparam int I_INT = 2;
    localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);
    localparam logic [VEC_W-1:0] SMI_V = VEC_W'(SMI_VEC);

    typedef struct packed {
        logic             smi;
        logic             nmi;
        logic             intr;
        logic [VEC_W-1:0] vec;
        logic             wake;
    } out_t;

    out_t o_d, o_q;
    logic [NSRC-1:0] ready, grant;
    logic nmi_ready, nmi_blocked, busy, done;

    assign ready[I_SMI] = smi_req;
    assign ready[I_NMI] = nmi_ready;
    assign ready[I_INT] = intr_lvl & ie_flag;

    evt_select #(.NSRC(NSRC)) u_sel (
        .boundary (insn_bnd),
        .busy     (busy),
        .ready    (ready),
        .grant    (grant)
    );

    evt_ack_fsm u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (grant[I_INT]),
        .ack_valid (ack_valid),
        .busy      (busy),
        .done      (done)
    );

    evt_nmi_track #(.NEST_W(NEST_W)) u_nmi (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_ctl     (nmi_ctl),
        .take_nmi    (grant[I_NMI]),
        .take_intr   (done),
        .iret_done   (iret_done),
        .nmi_ready   (nmi_ready),
        .nmi_blocked (nmi_blocked)
    );

    always_comb begin
        o_d      = o_q;
        o_d.smi  = grant[I_SMI];
        o_d.nmi  = grant[I_NMI];
        o_d.intr = done;
        if (grant[I_SMI]) o_d.vec = SMI_V;
        if (grant[I_NMI]) o_d.vec = NMI_V;
        if (done)         o_d.vec = ack_vec;
        // the NMI source is deliberately absent from the wake term
        o_d.wake = core_halted & (smi_req | (intr_lvl & ie_flag));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign ack_req   = busy;
    assign take_smi  = o_q.smi;
    assign take_nmi  = o_q.nmi;
    assign take_intr = o_q.intr;
    assign vector    = o_q.vec;
    assign wake      = o_q.wake;
endmodule

// File: rtl/evt_arbiter_chk.sv
`timescale 1ns/1ps
module evt_arbiter_chk #(
    parameter int VEC_W   = 8,
    parameter int NMI_VEC = 2,
    parameter int SMI_VEC = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smi_req,
    input logic             intr_lvl,
    input logic             ie_flag,
    input logic             insn_bnd,
    input logic             core_halted,
    input logic             ack_valid,
    input logic [VEC_W-1:0] ack_vec,
    input logic             ack_req,
    input logic             take_smi,
    input logic             take_nmi,
    input logic             take_intr,
    input logic [VEC_W-1:0] vector,
    input logic             wake
);
    p_one_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_smi, take_nmi, take_intr}));

    p_nmi_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |-> (vector == VEC_W'(NMI_VEC)) && !ack_req);

    p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_valid) |=> ack_req);

    p_intr_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_intr |-> $past(ack_req && ack_valid) && (vector == $past(ack_vec)));

    p_quiet_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> !take_smi && !take_nmi);

    p_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_smi || take_nmi) |-> $past(insn_bnd));

    p_wake_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(core_halted && (smi_req || (intr_lvl && ie_flag))));

    p_smi_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take_smi |-> vector == VEC_W'(SMI_VEC));
endmodule

bind evt_arbiter evt_arbiter_chk #(
    .VEC_W   (VEC_W),
    .NMI_VEC (NMI_VEC),
    .SMI_VEC (SMI_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smi_req     (smi_req),
    .intr_lvl    (intr_lvl),
    .ie_flag     (ie_flag),
    .insn_bnd    (insn_bnd),
    .core_halted (core_halted),
    .ack_valid   (ack_valid),
    .ack_vec     (ack_vec),
    .ack_req     (ack_req),
    .take_smi    (take_smi),
    .take_nmi    (take_nmi),
    .take_intr   (take_intr),
    .vector      (vector),
    .wake        (wake)
);

// File: tb/tb_evt_arbiter.sv
`timescale 1ns/1ps
module tb_evt_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smi_req = 0, intr_lvl = 0, nmi_ctl = 0, ie_flag = 0;
    logic       insn_bnd = 0, iret_done = 0, core_halted = 0, ack_valid = 0;
    logic [7:0] ack_vec = '0;
    logic       ack_req, take_smi, take_nmi, take_intr, wake;
    logic [7:0] vector;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    typedef struct { int kind; int vec; } exp_t;   // kind 1 SMI, 2 NMI, 3 INTR
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    evt_arbiter dut (
        .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .intr_lvl(intr_lvl),
        .nmi_ctl(nmi_ctl), .ie_flag(ie_flag), .insn_bnd(insn_bnd),
        .iret_done(iret_done), .core_halted(core_halted), .ack_valid(ack_valid),
        .ack_vec(ack_vec), .ack_req(ack_req), .take_smi(take_smi),
        .take_nmi(take_nmi), .take_intr(take_intr), .vector(vector), .wake(wake)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_take(input int kind, input int vec);
        exp_t e;
        e.kind = kind;
        e.vec  = vec;
        exp_q.push_back(e);
    endtask

    task automatic bnd();
        insn_bnd = 1'b1;
        cyc();
        insn_bnd = 1'b0;
    endtask

    task automatic ret();
        iret_done = 1'b1;
        cyc();
        iret_done = 1'b0;
    endtask

    task automatic nmi_edge();
        nmi_ctl = 1'b0;
        cyc();
        nmi_ctl = 1'b1;
        cyc();
    endtask

    task automatic no_take(input string req, input string what);
        chk(!(take_smi || take_nmi || take_intr), req, what,
            {take_smi, take_nmi, take_intr}, 0);
    endtask

    // called after the INTR boundary; completes the handshake
    task automatic finish_ack(input int vec);
        chk(ack_req == 1'b1, "R5", "ack_req after boundary", ack_req, 1);
        cyc(2);
        chk(ack_req == 1'b1, "R5", "ack_req held while waiting", ack_req, 1);
        ack_valid = 1'b1;
        ack_vec   = 8'(vec);
        expect_take(3, vec);
        cyc();
        ack_valid = 1'b0;
        chk(ack_req == 1'b0, "R5", "ack_req dropped after valid", ack_req, 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (take_smi || take_nmi || take_intr)) begin
            int kind;
            kind = take_smi ? 1 : (take_nmi ? 2 : 3);
            if (exp_q.size() == 0) begin
                chk(0, "R9", "unexpected take kind", kind, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(kind == e.kind, "R1", "take kind", kind, e.kind);
                chk(int'(vector) == e.vec,
                    kind == 1 ? "R12" : (kind == 2 ? "R3" : "R5"),
                    "take vector", int'(vector), e.vec);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R11: reset state
        chk(ack_req == 0 && wake == 0 && vector == 0, "R11", "reset outputs",
            {ack_req, wake, vector}, 0);
        no_take("R11", "takes in reset");
        rst_n = 1'b1;
        cyc(2);

        // R4: masked INTR does nothing
        intr_lvl = 1'b1; ie_flag = 1'b0;
        bnd();
        chk(ack_req == 0, "R4", "no ack when masked", ack_req, 0);
        no_take("R4", "masked intr take");

        // R5: enabled INTR handshake
        ie_flag = 1'b1;
        bnd();
        intr_lvl = 1'b0;
        finish_ack(8'h5A);
        cyc(2);

        // R2/R9: NMI edge, no take without a boundary
        nmi_edge();
        cyc(3);
        no_take("R9", "take without boundary");
        expect_take(2, 2);
        bnd();
        chk(ack_req == 0, "R3", "no ack for NMI", ack_req, 0);
        // R7: two edges while blocked, only one kept
        nmi_edge();
        nmi_edge();
        bnd();
        no_take("R7", "NMI while blocked");
        ret();
        expect_take(2, 2);
        bnd();
        ret();
        bnd();
        no_take("R7", "second edge lost");
        // R2: held level does not retrigger
        cyc(2);
        bnd();
        no_take("R2", "held level retrigger");
        nmi_ctl = 1'b0;
        cyc();

        // R8: nested INTR inside NMI handler
        nmi_edge();
        expect_take(2, 2);
        bnd();
        intr_lvl = 1'b1;
        bnd();
        intr_lvl = 1'b0;
        finish_ack(8'h33);
        nmi_edge();
        bnd();
        no_take("R8", "NMI before nested return");
        ret();
        bnd();
        no_take("R8", "NMI after INTR return only");
        ret();
        expect_take(2, 2);
        bnd();
        ret();
        nmi_ctl = 1'b0;
        cyc();

        // R1: priority with all three ready
        nmi_edge();
        smi_req = 1'b1; intr_lvl = 1'b1;
        expect_take(1, 0);
        bnd();
        smi_req = 1'b0;
        expect_take(2, 2);
        bnd();
        bnd();
        intr_lvl = 1'b0;
        finish_ack(8'hC7);
        ret();
        ret();
        nmi_ctl = 1'b0;
        cyc();

        // R6: boundaries ignored during a handshake
        intr_lvl = 1'b1;
        bnd();
        intr_lvl = 1'b0;
        smi_req = 1'b1;
        bnd();
        no_take("R6", "SMI during handshake");
        bnd();
        no_take("R6", "SMI during handshake again");
        finish_ack(8'h81);
        expect_take(1, 0);
        bnd();
        smi_req = 1'b0;
        cyc();

        // R10: wake sources
        nmi_edge();
        expect_take(2, 2);
        bnd();
        nmi_edge();               // held NMI while blocked
        core_halted = 1'b1;
        cyc(2);
        chk(wake == 0, "R10", "pending NMI must not wake", wake, 0);
        intr_lvl = 1'b1; ie_flag = 1'b0;
        cyc();
        chk(wake == 0, "R10", "masked INTR no wake", wake, 0);
        ie_flag = 1'b1;
        cyc();
        chk(wake == 1, "R10", "enabled INTR wakes", wake, 1);
        intr_lvl = 1'b0; smi_req = 1'b1;
        cyc();
        chk(wake == 1, "R10", "SMI wakes", wake, 1);
        smi_req = 1'b0; core_halted = 1'b0;
        cyc();
        chk(wake == 0, "R10", "wake drops", wake, 0);

        // R11: reset mid-handshake clears blocked state and held NMI
        intr_lvl = 1'b1;
        bnd();
        intr_lvl = 1'b0;
        nmi_ctl = 1'b0;
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc();
        chk(ack_req == 0, "R11", "handshake cleared", ack_req, 0);
        chk(vector == 0, "R11", "vector cleared", vector, 0);
        bnd();
        no_take("R11", "held NMI cleared");
        nmi_edge();
        expect_take(2, 2);
        bnd();
        ret();
        cyc(3);

        chk(exp_q.size() == 0, "R1", "expected takes left over", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule